// File: doc/BRIEF.md
# Address-Randomising RAM Scrambler

This block sits between a processor's data port and a word-organised RAM, so that the contents of the RAM show little about the program's layout. Each access is moved to a different physical word. The move is an XOR of the processor address with a layout seed. Each stored word is also masked with a second seed and with the processor address, so the same value written at two addresses is stored as two different patterns. On a read the block removes both masks, and the processor sees ordinary memory as long as the seeds do not change.

The two seeds live in write-only registers on the same port. Only a firmware-privileged access can change them. An application-mode write to either seed is discarded without any error, and a read of either seed address returns zero. Firmware can load new seeds at any time. After a reseed, words that were stored earlier decode to different values and land at different positions.

The RAM window spans the 128 KiB region from byte address 0x4000_0000 to 0x4001_FFFF. The physical array has `IDX_W` index bits: 15 bits gives the full 32K words, and the default of 10 bits gives a small array in which the window aliases. Reads return data one cycle after the request.

Top module: `ramScrambler`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `cpuRvalid` is low, and both seeds hold zero.
- R2: A RAM access uses the physical word index `(cpuAddr XOR layoutSeed)[IDX_W+1:2]`. The other bits of the layout seed have no effect.
- R3: A write to the RAM stores `cpuWdata XOR dataSeed XOR cpuAddr` at the index given by R2.
- R4: A read passes the stored word through the same two XOR operations. A read after a write to the same address, with both seeds unchanged, returns the written value.
- R5: An address is a RAM access only when `cpuAddr[31:17]` equals 15'h2000, which is byte range 0x4000_0000 to 0x4001_FFFF. A write outside this range and outside the seed addresses changes nothing. A read outside the range returns zero.
- R6: The layout seed sits at 0xFF00_0040 and the data seed at 0xFF00_0044. A write with any nonzero strobe loads all 32 bits. A read of either address returns zero.
- R7: A seed write with `fwMode` low is dropped, and the seed keeps its previous value.
- R8: After a seed is rewritten, earlier stored words read back as given by R2 to R4 under the new seeds, which is in general a different value.
- R9: `cpuWstrb[k]` writes byte lane k (bits 8k+7:8k) of the masked word. The other lanes of the stored word are kept.
- R10: A request with `cpuWstrb` zero is a read. `cpuRvalid` is high in exactly the following cycle, with `cpuRdata` valid in that cycle. `cpuRvalid` is low in every other cycle.
- R11: Addresses whose index bits agree under R2 select the same physical word, so every address in the window lands inside the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fwMode | input | 1 | High when the current access is firmware-privileged |
| cpuReq | input | 1 | Access request this cycle |
| cpuAddr | input | 32 | Byte address of the access |
| cpuWstrb | input | 4 | Byte write strobes; zero means read |
| cpuWdata | input | 32 | Write data |
| cpuRvalid | output | 1 | Read data valid, one cycle after a read request |
| cpuRdata | output | 32 | Read data |

## Verification
The assertions assume that the inputs are stable and known across each rising edge. They also assume that `fwMode` describes the request presented in the same cycle. The bench meets both conditions by changing every input only at the falling edge, from a single task. It also presents at most one access per cycle. The bench first fills every physical word with seeds at zero, so no later read meets uninitialised storage. It uses only word-aligned addresses.

// File: rtl/scramblerPkg.sv
package scramblerPkg;
  localparam int DATA_W = 32;
  localparam int LANES = DATA_W / 8;
  localparam int WIN_BITS = 17;
  localparam logic [31:0] RAM_BASE = 32'h4000_0000;
  localparam logic [31:0] LAYOUT_SEED_ADDR = 32'hFF00_0040;
  localparam logic [31:0] DATA_SEED_ADDR = 32'hFF00_0044;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_RAM,
    ACC_LAYOUT,
    ACC_DATA,
    ACC_OTHER
  } accessKind_e;

  typedef struct packed {
    logic [LANES-1:0] ramWe;
    logic ramRe;
    logic layoutWe;
    logic dataWe;
    logic anyRead;
  } ctrlStrobes_t;
endpackage

// File: rtl/scramblerCtrl.sv
module scramblerCtrl
  import scramblerPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic fwMode,
  input  logic cpuReq,
  input  logic [31:0] cpuAddr,
  input  logic [LANES-1:0] cpuWstrb,
  output ctrlStrobes_t strobes,
  output logic rdValid,
  output logic rdFromRam
);
  accessKind_e kind;
  logic isWrite;

  assign isWrite = |cpuWstrb;

  always_comb begin
    if (!cpuReq) kind = ACC_NONE;
    else if (cpuAddr[31:WIN_BITS] == RAM_BASE[31:WIN_BITS]) kind = ACC_RAM;
    else if (cpuAddr == LAYOUT_SEED_ADDR) kind = ACC_LAYOUT;
    else if (cpuAddr == DATA_SEED_ADDR) kind = ACC_DATA;
    else kind = ACC_OTHER;
  end

  always_comb begin
    strobes = '0;
    strobes.anyRead = (kind != ACC_NONE) && !isWrite;
    unique case (kind)
      ACC_RAM: begin
        strobes.ramWe = cpuWstrb;
        strobes.ramRe = !isWrite;
      end
      ACC_LAYOUT: strobes.layoutWe = isWrite && fwMode;
      ACC_DATA:   strobes.dataWe = isWrite && fwMode;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdFromRam <= 1'b0;
    end else begin
      rdValid <= strobes.anyRead;
      rdFromRam <= strobes.ramRe;
    end
  end
endmodule

// File: rtl/scramblerSeeds.sv
module scramblerSeeds
  import scramblerPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  ctrlStrobes_t strobes,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] layoutSeed,
  output logic [DATA_W-1:0] dataSeed
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      layoutSeed <= '0;
      dataSeed <= '0;
    end else begin
      if (strobes.layoutWe) layoutSeed <= cpuWdata;
      if (strobes.dataWe) dataSeed <= cpuWdata;
    end
  end
endmodule

// File: rtl/scramblerDatapath.sv
module scramblerDatapath
  import scramblerPkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic clk,
  input  logic rstN,
  input  ctrlStrobes_t strobes,
  input  logic rdFromRam,
  input  logic [31:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [IDX_W-1:0] layoutIdxSeed,
  input  logic [DATA_W-1:0] dataSeed,
  input  logic [DATA_W-1:0] ramQ,
  output logic [IDX_W-1:0] ramIdx,
  output logic [DATA_W-1:0] ramWdata,
  output logic [DATA_W-1:0] cpuRdata
);
  logic [DATA_W-1:0] accessMask;
  logic [DATA_W-1:0] maskQ;

  assign accessMask = dataSeed ^ cpuAddr;
  assign ramIdx = cpuAddr[IDX_W+1:2] ^ layoutIdxSeed;
  assign ramWdata = cpuWdata ^ accessMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) maskQ <= '0;
    else if (strobes.ramRe) maskQ <= accessMask;
  end

  assign cpuRdata = rdFromRam ? (ramQ ^ maskQ) : '0;
endmodule

// File: rtl/scramblerRam.sv
module scramblerRam
  import scramblerPkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic clk,
  input  logic [IDX_W-1:0] idx,
  input  logic [LANES-1:0] we,
  input  logic re,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  localparam int DEPTH = 1 << IDX_W;
  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar lane = 0; lane < LANES; lane++) begin : gLane
    always_ff @(posedge clk) begin
      if (we[lane]) mem[idx][lane*8 +: 8] <= wdata[lane*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (re) q <= mem[idx];
  end
endmodule

// File: rtl/ramScrambler.sv
module ramScrambler
  import scramblerPkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic clk,
  input  logic rstN,
  input  logic fwMode,
  input  logic cpuReq,
  input  logic [31:0] cpuAddr,
  input  logic [3:0] cpuWstrb,
  input  logic [31:0] cpuWdata,
  output logic cpuRvalid,
  output logic [31:0] cpuRdata
);
  ctrlStrobes_t strobes;
  logic rdFromRam;
  logic [DATA_W-1:0] layoutSeed;
  logic [DATA_W-1:0] dataSeed;
  logic [IDX_W-1:0] ramIdx;
  logic [DATA_W-1:0] ramWdata;
  logic [DATA_W-1:0] ramQ;

  scramblerCtrl uCtrl (
    .clk(clk), .rstN(rstN), .fwMode(fwMode), .cpuReq(cpuReq),
    .cpuAddr(cpuAddr), .cpuWstrb(cpuWstrb), .strobes(strobes),
    .rdValid(cpuRvalid), .rdFromRam(rdFromRam)
  );

  scramblerSeeds uSeeds (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cpuWdata(cpuWdata),
    .layoutSeed(layoutSeed), .dataSeed(dataSeed)
  );

  scramblerDatapath #(.IDX_W(IDX_W)) uPath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rdFromRam(rdFromRam),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .layoutIdxSeed(layoutSeed[IDX_W+1:2]), .dataSeed(dataSeed),
    .ramQ(ramQ), .ramIdx(ramIdx), .ramWdata(ramWdata), .cpuRdata(cpuRdata)
  );

  scramblerRam #(.IDX_W(IDX_W)) uRam (
    .clk(clk), .idx(ramIdx), .we(strobes.ramWe), .re(strobes.ramRe),
    .wdata(ramWdata), .q(ramQ)
  );
endmodule

// File: rtl/scramblerChecker.sv
module scramblerChecker (
  input logic clk,
  input logic rstN,
  input logic fwMode,
  input logic cpuReq,
  input logic [31:0] cpuAddr,
  input logic [3:0] cpuWstrb,
  input logic cpuRvalid,
  input logic [31:0] cpuRdata,
  input logic [31:0] layoutSeed,
  input logic [31:0] dataSeed
);
  logic readReq;
  logic offMapRead;
  assign readReq = cpuReq && (cpuWstrb == 4'b0);
  assign offMapRead = readReq && (cpuAddr[31:17] != 15'h2000);

  AST_READ_GIVES_VALID: assert property (@(posedge clk) disable iff (!rstN)
    readReq |=> cpuRvalid); // R10
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !readReq |=> !cpuRvalid); // R10
  AST_OFFMAP_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    offMapRead |=> (cpuRdata == 32'h0)); // R5
  AST_LAYOUT_HELD_APP: assert property (@(posedge clk) disable iff (!rstN)
    !fwMode |=> $stable(layoutSeed)); // R7
  AST_DATA_HELD_APP: assert property (@(posedge clk) disable iff (!rstN)
    !fwMode |=> $stable(dataSeed)); // R7
  AST_LAYOUT_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !(cpuReq && (cpuWstrb != 4'b0) && (cpuAddr == 32'hFF00_0040)) |=> $stable(layoutSeed)); // R6
  AST_DATA_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !(cpuReq && (cpuWstrb != 4'b0) && (cpuAddr == 32'hFF00_0044)) |=> $stable(dataSeed)); // R6
endmodule

bind ramScrambler scramblerChecker chk (
  .clk(clk), .rstN(rstN), .fwMode(fwMode), .cpuReq(cpuReq),
  .cpuAddr(cpuAddr), .cpuWstrb(cpuWstrb), .cpuRvalid(cpuRvalid),
  .cpuRdata(cpuRdata), .layoutSeed(layoutSeed), .dataSeed(dataSeed)
);

// File: tb/tb_ramScrambler.sv
module tb_ramScrambler;
  localparam int IDX_W = 10;
  localparam int NW = 1 << IDX_W;
  localparam logic [31:0] BASE = 32'h4000_0000;
  localparam logic [31:0] LAY_A = 32'hFF00_0040;
  localparam logic [31:0] DAT_A = 32'hFF00_0044;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fwMode = 1'b0;
  logic cpuReq = 1'b0;
  logic [31:0] cpuAddr = '0;
  logic [3:0] cpuWstrb = '0;
  logic [31:0] cpuWdata = '0;
  logic cpuRvalid;
  logic [31:0] cpuRdata;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [31:0] phys [NW];
  logic [31:0] mLay = '0;
  logic [31:0] mDat = '0;
  bit pendValid = 1'b0;
  logic [31:0] pendData = '0;
  string pendTag = "R1";

  always #5 clk = ~clk;

  ramScrambler #(.IDX_W(IDX_W)) dut (
    .clk(clk), .rstN(rstN), .fwMode(fwMode), .cpuReq(cpuReq),
    .cpuAddr(cpuAddr), .cpuWstrb(cpuWstrb), .cpuWdata(cpuWdata),
    .cpuRvalid(cpuRvalid), .cpuRdata(cpuRdata)
  );

  function automatic bit inRam(logic [31:0] a);
    return a[31:17] == 15'h2000;
  endfunction

  function automatic int unsigned idxOf(logic [31:0] a);
    return int'(((a ^ mLay) >> 2) & (NW - 1));
  endfunction

  task automatic compareNow();
    checks++;
    if (cpuRvalid !== pendValid) begin
      errors++;
      $display("FAIL %s (R10): rvalid=%0b expected %0b", pendTag, cpuRvalid, pendValid);
    end
    if (pendValid) begin
      checks++;
      if (cpuRdata !== pendData) begin
        errors++;
        $display("FAIL %s: rdata=%08h expected %08h", pendTag, cpuRdata, pendData);
      end
    end
  endtask

  // one access per cycle; called at a falling edge
  task automatic step(bit fw, bit req, logic [31:0] a, logic [3:0] s,
                      logic [31:0] d, string tag);
    compareNow();
    fwMode = fw; cpuReq = req; cpuAddr = a; cpuWstrb = s; cpuWdata = d;
    pendValid = req && (s == 4'b0);
    pendData = '0;
    pendTag = tag;
    if (pendValid && inRam(a)) pendData = phys[idxOf(a)] ^ mDat ^ a;
    if (req && (s != 4'b0)) begin
      if (inRam(a)) begin
        for (int k = 0; k < 4; k++)
          if (s[k]) phys[idxOf(a)][k*8 +: 8] = (d ^ mDat ^ a) >> (k*8);
      end else if (fw && a == LAY_A) mLay = d;
      else if (fw && a == DAT_A) mDat = d;
    end
    @(negedge clk);
  endtask

  task automatic idle(string tag);
    step(1'b0, 1'b0, '0, 4'h0, '0, tag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1: no valid during reset
    checks++;
    if (cpuRvalid !== 1'b0) begin
      errors++;
      $display("FAIL R1: rvalid=%0b expected 0 in reset", cpuRvalid);
    end
    rstN = 1'b1;
    @(negedge clk);
    idle("R1");
    idle("R1");

    // R3 R4: fill every physical word with seeds zero (R1 seeds reset)
    for (int i = 0; i < NW; i++)
      step(1'b1, 1'b1, BASE + 32'(i * 4), 4'hF, 32'(i) * 32'h9E37_79B1, "R3");
    for (int i = 0; i < NW; i++)
      step(1'b1, 1'b1, BASE + 32'(i * 4), 4'h0, '0, "R4 transparent, R1 zero seeds");

    // R10: back-to-back reads, then read gap read
    step(1'b0, 1'b1, BASE + 32'h10, 4'h0, '0, "R10");
    step(1'b0, 1'b1, BASE + 32'h14, 4'h0, '0, "R10");
    idle("R10");
    step(1'b0, 1'b1, BASE + 32'h18, 4'h0, '0, "R10");

    // R2 R8: rekey layout (junk low bits) then data seed, reread
    step(1'b1, 1'b1, LAY_A, 4'h1, 32'h1234_5A67, "R2");
    for (int i = 0; i < 16; i++)
      step(1'b0, 1'b1, BASE + 32'(i * 4), 4'h0, '0, "R2 R8 layout rekey");
    step(1'b1, 1'b1, DAT_A, 4'h8, 32'hC0DE_F00D, "R3");
    for (int i = 0; i < 16; i++)
      step(1'b0, 1'b1, BASE + 32'(i * 68), 4'h0, '0, "R3 R8 data rekey");

    // R4: write/read under new seeds
    step(1'b0, 1'b1, BASE + 32'h100, 4'hF, 32'hDEAD_BEEF, "R4");
    step(1'b0, 1'b1, BASE + 32'h100, 4'h0, '0, "R4 roundtrip");

    // R7: application-mode seed writes dropped
    step(1'b0, 1'b1, LAY_A, 4'hF, 32'hFFFF_FFFF, "R7");
    step(1'b0, 1'b1, DAT_A, 4'hF, 32'h5555_5555, "R7");
    step(1'b0, 1'b1, BASE + 32'h100, 4'h0, '0, "R7 seeds kept");
    step(1'b0, 1'b1, BASE + 32'h3C, 4'h0, '0, "R7 seeds kept");

    // R6: seeds write-only
    step(1'b1, 1'b1, LAY_A, 4'h0, '0, "R6 layout read zero");
    step(1'b1, 1'b1, DAT_A, 4'h0, '0, "R6 data read zero");

    // R5: window boundaries and outside accesses
    step(1'b1, 1'b1, 32'h4001_FFFC, 4'hF, 32'hA5A5_0001, "R5");
    step(1'b1, 1'b1, 32'h4001_FFFC, 4'h0, '0, "R5 last word");
    step(1'b1, 1'b1, BASE, 4'hF, 32'h0BAD_CAFE, "R5");
    step(1'b1, 1'b1, BASE, 4'h0, '0, "R5 first word");
    step(1'b1, 1'b1, 32'h4002_0000, 4'hF, 32'h1111_1111, "R5");
    step(1'b1, 1'b1, 32'h3FFF_FFFC, 4'hF, 32'h2222_2222, "R5");
    step(1'b1, 1'b1, 32'h4002_0000, 4'h0, '0, "R5 outside read zero");
    step(1'b1, 1'b1, 32'h3FFF_FFFC, 4'h0, '0, "R5 outside read zero");
    for (int i = 0; i < NW; i++)
      step(1'b0, 1'b1, BASE + 32'(i * 4), 4'h0, '0, "R5 ram untouched");

    // R9: byte lanes
    step(1'b0, 1'b1, BASE + 32'h200, 4'b0101, 32'h1122_3344, "R9");
    step(1'b0, 1'b1, BASE + 32'h200, 4'h0, '0, "R9 lanes 0 2");
    step(1'b0, 1'b1, BASE + 32'h200, 4'b1000, 32'hFF00_0000, "R9");
    step(1'b0, 1'b1, BASE + 32'h200, 4'h0, '0, "R9 lane 3");

    // R11: alias of index across the window
    step(1'b1, 1'b1, LAY_A, 4'hF, 32'hFFFF_FFFF, "R11");
    step(1'b0, 1'b1, BASE + 32'h1_0000, 4'hF, 32'h7777_8888, "R11");
    step(1'b0, 1'b1, BASE + 32'h1_0000, 4'h0, '0, "R11 alias");
    step(1'b0, 1'b1, BASE, 4'h0, '0, "R11 alias shared word");
    step(1'b0, 1'b1, BASE + 32'h1000, 4'h0, '0, "R11 alias shared word");
    idle("R10");
    idle("R10");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule